// File: doc/BRIEF.md
# Interrupt Status, Mask and Clear Bank

This block gathers interrupt conditions from a serial bus controller's transmit and receive FIFOs and from its transaction sequencer. It shows them through three read views: a raw status word, a mask word, and a masked status word. It also accepts a write-one-to-clear word for the sticky sources. A single level interrupt line is raised whenever any enabled source is active.

The sources come in two kinds. The FIFO fill conditions are level sources. They always show the present state of the FIFOs and cannot be cleared. The transaction events, and the transmit overrun, are one-cycle pulses. Each pulse is caught in a sticky bit that holds until software clears it.

The bit map is fixed and sparse:

| Bit | Kind | Meaning |
|-----|------|---------|
| 0 | level | transmit empty |
| 1 | level | transmit nearly empty |
| 2 | level | transmit full |
| 3 | event | transmit overrun |
| 4 | level | receive empty |
| 5 | level | receive nearly full |
| 6 | level | receive full |
| 16 | event | slave read request |
| 17 | event | slave read with empty FIFO |
| 18 | event | slave write request |
| 19 | event | master transaction done |
| 20 | event | slave transaction done |
| 24 | event | arbitration lost |
| 25 | event | bus error |
| 28 | event | master done without stop |

All other bits are not implemented. The set of implemented bits is 0x131F007F.

Top module: `irq_status_bank`

## Requirements
- R1: Raw status bits 0,1,2,4,5,6 equal the matching `src_level` bits in the same cycle. A clear write never changes them.
- R2: A 1 on an event bit of `src_pulse` (bits 3,16,17,18,19,20,24,25,28) sets that raw status bit after the next rising edge. The bit then stays 1 until a clear write targets it.
- R3: A clear write (`clr_wr_en`=1) sets to 0, at that edge, every latched event bit whose `clr_wr_data` bit is 1. Event bits whose clear bit is 0 keep their value. Writing 0x131F007F clears all events.
- R4: If a pulse and a clear write hit the same event bit in the same cycle, the bit is 1 afterwards.
- R5: Bits outside 0x131F007F read 0 in raw status, mask and masked status, whatever the inputs and writes.
- R6: Masked status equals raw status AND the mask word.
- R7: A mask write (`mask_wr_en`=1) replaces the mask word with `mask_wr_data` AND 0x131F007F at the next edge. Writing 0 disables every interrupt.
- R8: `irq_o` at each edge takes the OR of the masked status seen just before that edge. It therefore rises one cycle after any masked bit becomes 1.
- R9: While reset is asserted, and just after it is released, the mask, the latched events and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level | input | 32 | Live FIFO conditions; only the level bits are used |
| src_pulse | input | 32 | One-cycle event pulses; only the event bits are used |
| mask_wr_en | input | 1 | Mask word write strobe |
| mask_wr_data | input | 32 | New mask word |
| clr_wr_en | input | 1 | Clear word write strobe |
| clr_wr_data | input | 32 | Write-one-to-clear bits |
| raw_stat | output | 32 | Raw status word |
| mask_stat | output | 32 | Current mask word |
| masked_stat | output | 32 | Raw status AND mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Level bits reach `raw_stat` and `masked_stat` in the same cycle they are driven. An event pulse, a clear write or a mask write shows up one edge later. `irq_o` follows the masked status one more edge after that.

The bench drives each cycle's stimulus just after a rising edge. It then pushes the expected views for that cycle, taken from a reference model that has already been advanced by the edge. The monitor samples three quarters of the way through the same cycle. As a result, every expectation accounts for exactly the registers between the stimulus and the port being checked.

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int          DW         = 32,
  parameter logic [31:0] IMPL_MASK  = 32'h131F_007F,
  parameter logic [31:0] LEVEL_MASK = 32'h0000_0077
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_level,
  input  logic [DW-1:0] src_pulse,
  input  logic          mask_wr_en,
  input  logic [DW-1:0] mask_wr_data,
  input  logic          clr_wr_en,
  input  logic [DW-1:0] clr_wr_data,
  output logic [DW-1:0] raw_stat,
  output logic [DW-1:0] mask_stat,
  output logic [DW-1:0] masked_stat,
  output logic          irq_o
);

  localparam logic [DW-1:0] IMPL  = IMPL_MASK[DW-1:0];
  localparam logic [DW-1:0] LEVEL = LEVEL_MASK[DW-1:0] & IMPL;
  localparam logic [DW-1:0] EVENT = IMPL & ~LEVEL;

  logic [DW-1:0] evt_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] clr_bits;

  assign clr_bits = clr_wr_en ? (clr_wr_data & EVENT) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      evt_q <= ((evt_q & ~clr_bits) | src_pulse) & EVENT;
      if (mask_wr_en) mask_q <= mask_wr_data & IMPL;
      irq_o <= |masked_stat;
    end
  end

  assign raw_stat    = (src_level & LEVEL) | evt_q;
  assign mask_stat   = mask_q;
  assign masked_stat = raw_stat & mask_q;

endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int          DW         = 32,
  parameter logic [31:0] IMPL_MASK  = 32'h131F_007F,
  parameter logic [31:0] LEVEL_MASK = 32'h0000_0077
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] src_level,
  input logic [DW-1:0] src_pulse,
  input logic          mask_wr_en,
  input logic [DW-1:0] mask_wr_data,
  input logic          clr_wr_en,
  input logic [DW-1:0] clr_wr_data,
  input logic [DW-1:0] raw_stat,
  input logic [DW-1:0] mask_stat,
  input logic [DW-1:0] masked_stat,
  input logic          irq_o
);

  localparam logic [DW-1:0] IMPL  = IMPL_MASK[DW-1:0];
  localparam logic [DW-1:0] LEVEL = LEVEL_MASK[DW-1:0] & IMPL;
  localparam logic [DW-1:0] EVENT = IMPL & ~LEVEL;

  assert_level_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat & LEVEL) == (src_level & LEVEL));

  assert_event_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_en |=> ((raw_stat & EVENT & $past(raw_stat & EVENT)) == $past(raw_stat & EVENT)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_en && ((src_pulse & EVENT) == '0)) |=> ((raw_stat & EVENT & $past(clr_wr_data)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_pulse & EVENT)) |=> ((raw_stat & $past(src_pulse & EVENT)) == $past(src_pulse & EVENT)));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_stat | mask_stat | masked_stat) & ~IMPL) == '0);

  assert_masked_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_stat & ~mask_stat) == '0) && ((masked_stat & ~raw_stat) == '0));

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> (mask_stat == ($past(mask_wr_data) & IMPL)));

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|masked_stat)));

endmodule

bind irq_status_bank irq_status_bank_chk #(
  .DW(DW), .IMPL_MASK(IMPL_MASK), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_pulse(src_pulse),
  .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
  .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
  .raw_stat(raw_stat), .mask_stat(mask_stat), .masked_stat(masked_stat),
  .irq_o(irq_o)
);

// File: tb/tb_irq_status_bank.sv
`timescale 1ns/1ps
module tb_irq_status_bank;
  localparam logic [31:0] IMPL  = 32'h131F_007F;
  localparam logic [31:0] LEVEL = 32'h0000_0077;
  localparam logic [31:0] EVENT = IMPL & ~LEVEL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src_level = '0, src_pulse = '0, mask_wr_data = '0, clr_wr_data = '0;
  logic mask_wr_en = 1'b0, clr_wr_en = 1'b0;
  logic [31:0] raw_stat, mask_stat, masked_stat;
  logic irq_o;

  always #2 clk = ~clk;

  irq_status_bank dut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_pulse(src_pulse),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .raw_stat(raw_stat), .mask_stat(mask_stat), .masked_stat(masked_stat),
    .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  logic [31:0] q_raw[$], q_mask[$], q_msk[$];
  logic        q_irq[$];
  string       q_tag[$];

  logic [31:0] ev_m = '0, mask_m = '0;
  logic        irq_m = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input logic [31:0] lvl, input logic [31:0] pls,
                      input logic mwe, input logic [31:0] mwd,
                      input logic cwe, input logic [31:0] cwd, input string tag);
    logic [31:0] e_raw, e_msk;
    @(posedge clk); #1;
    src_level = lvl; src_pulse = pls;
    mask_wr_en = mwe; mask_wr_data = mwd;
    clr_wr_en = cwe; clr_wr_data = cwd;
    e_raw = (lvl & LEVEL) | ev_m;
    e_msk = e_raw & mask_m;
    q_raw.push_back(e_raw); q_mask.push_back(mask_m);
    q_msk.push_back(e_msk); q_irq.push_back(irq_m); q_tag.push_back(tag);
    ev_m  = ((ev_m & ~(cwe ? cwd : 32'h0)) | pls) & EVENT;
    if (mwe) mask_m = mwd & IMPL;
    irq_m = |e_msk;
  endtask

  initial begin
    forever begin
      @(posedge clk); #3;
      if (q_tag.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check(t, "raw",    raw_stat,    q_raw.pop_front());
        check(t, "mask",   mask_stat,   q_mask.pop_front());
        check(t, "masked", masked_stat, q_msk.pop_front());
        check(t, "irq",    {31'h0, irq_o}, {31'h0, q_irq.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    src_pulse = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    #3;
    check("R9", "raw in reset", raw_stat, 32'h0);
    check("R9", "irq in reset", {31'h0, irq_o}, 32'h0);
    src_pulse = '0;
    @(posedge clk); #1; rst_n = 1'b1;
    tick(0, 0, 0, 0, 0, 0, "R9");
    tick(32'h77, 0, 0, 0, 0, 0, "R1");
    tick(32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R5");
    tick(0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, 1, 32'h0001_0008, "R3");
    tick(32'h77, 0, 0, 0, 1, 32'hFFFF_FFFF, "R3");
    tick(32'h77, 0, 0, 0, 0, 0, "R1");
    tick(0, 32'h0008_0000, 0, 0, 1, 32'h0008_0000, "R4");
    tick(0, 32'h0100_0000, 0, 0, 1, 32'h0108_0000, "R4");
    tick(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R4");
    tick(32'h22, 0, 0, 0, 0, 0, "R6");
    tick(32'h22, 0, 0, 0, 0, 0, "R8");
    tick(0, 0, 1, 32'h0, 1, IMPL, "R7");
    tick(0, 0, 0, 0, 0, 0, "R7");
    tick(0, 0, 1, 32'h0200_0000, 0, 0, "R8");
    tick(0, 32'h0200_0000, 0, 0, 0, 0, "R8");
    tick(0, 0, 0, 0, 0, 0, "R8");
    tick(0, 0, 0, 0, 1, 32'h0200_0000, "R8");
    tick(0, 0, 0, 0, 0, 0, "R8");
    tick(0, 0, 0, 0, 0, 0, "R8");
    @(posedge clk); #4;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule